// File: doc/BRIEF.md
# Parallel EPROM Bank Read Controller

This block lets a synchronous host read bytes from a bank of byte-wide parallel EPROMs. The devices share one address bus and one data bus. The host presents a flat byte address with a request. The controller treats the top bits of that address as a device number and the remaining bits as the location inside that device. It pulls low the active-low chip enable of the selected device only. It then opens the single output enable line that all devices share. After a programmed number of clock cycles it captures the byte on the data bus and returns it with a one-cycle valid strobe.

Access timing is expressed in clock cycles. One parameter sets the full access time, counted from the moment address and chip enable are applied. A second parameter sets the shorter delay from the output enable falling to data being valid. The controller keeps the output enable high for the difference between the two, so the device has been selected and addressed long enough before its outputs open. Between reads every chip enable and the output enable return high, which leaves every device in standby. No two devices can ever drive the shared data bus at the same time.

Top module: `eprom_array_reader`

## Requirements
- R1: While reset is held and whenever no read is in progress, every bit of `mem_ce_n_o` is 1, `mem_oe_n_o` is 1, `ready_o` is 1 and `valid_o` is 0.
- R2: For an accepted request, the device index is `addr_i[ADDR_W-1:DEV_ADDR_W]`. Bit i of `mem_ce_n_o` is 0 only for that index, and `mem_addr_o` carries `addr_i[DEV_ADDR_W-1:0]` for the whole read.
- R3: At most one bit of `mem_ce_n_o` is 0 in any cycle.
- R4: Counting the first cycle after the accepting edge as cycle 0, `mem_oe_n_o` is 0 exactly in cycles T_ACC−T_OE through T_ACC−1. Chip enable and address are applied from cycle 0.
- R5: `valid_o` is 1 for exactly cycle T_ACC. In that cycle `data_o` holds the bus value captured at the clock edge that ends the output-enable window.
- R6: `mem_oe_n_o` returns high one cycle before the chip enable is released. Chip enables never move straight from one device to another: at least one cycle with every enable high separates two reads.
- R7: `ready_o` is 1 only when idle. A request is accepted only on an edge where `ready_o` is 1. Requests and address changes while busy have no effect on any output.
- R8: `mem_oe_n_o` is 0 only while exactly one chip enable is 0. Chip enable and address do not change while the output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host read request |
| addr_i | input | ADDR_W | Flat byte address (device index in the upper bits) |
| ready_o | output | 1 | Controller idle, request will be taken |
| data_o | output | DATA_W | Captured byte |
| valid_o | output | 1 | One-cycle strobe marking `data_o` |
| mem_addr_o | output | DEV_ADDR_W | Shared in-device address bus |
| mem_ce_n_o | output | NUM_DEV | Per-device active-low chip enables |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_data_i | input | DATA_W | Shared device data bus |

## Verification
The bench builds the block with its defaults: four devices of 15 address bits, T_ACC of 4 and T_OE of 2. With these values the setup phase and the output-enable window are both two cycles long and non-empty. Each device boundary (0x7FFF/0x8000 and so on) and the last address 0x1FFFF can be reached. A bus model outputs unknown data when a device is read before its chip-enable or output-enable time has run out, or when two devices are enabled together. Because of this, an early strobe or a missing gap shows up as a wrong byte as well as a wrong enable pattern.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE    = 2'd0,
        RD_SETUP   = 2'd1,
        RD_STROBE  = 2'd2,
        RD_RELEASE = 2'd3
    } rd_state_e;

endpackage

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int DEV_W      = 2,
    parameter int DEV_ADDR_W = 15,
    parameter int T_ACC      = 4,
    parameter int T_OE       = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_i,
    input  logic [DEV_W+DEV_ADDR_W-1:0] addr_i,
    output logic                        ready_o,
    output logic                        active_o,
    output logic                        strobe_o,
    output logic                        take_o,
    output logic [DEV_W-1:0]            dev_o,
    output logic [DEV_ADDR_W-1:0]       lo_o
);

    localparam int N_SETUP = T_ACC - T_OE;
    localparam int CNT_W   = $clog2(T_ACC + 1);

    typedef struct packed {
        rd_state_e             state;
        logic [CNT_W-1:0]      cnt;
        logic [DEV_W-1:0]      dev;
        logic [DEV_ADDR_W-1:0] lo;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_setup, last_strobe;

    always_comb begin
        seq_d       = seq_q;
        last_setup  = (int'(seq_q.cnt) == N_SETUP - 1);
        last_strobe = (int'(seq_q.cnt) == T_OE - 1);
        unique case (seq_q.state)
            RD_IDLE: begin
                if (req_i) begin
                    seq_d.dev   = addr_i[DEV_W+DEV_ADDR_W-1:DEV_ADDR_W];
                    seq_d.lo    = addr_i[DEV_ADDR_W-1:0];
                    seq_d.cnt   = '0;
                    seq_d.state = (N_SETUP == 0) ? RD_STROBE : RD_SETUP;
                end
            end
            RD_SETUP: begin
                if (last_setup) begin
                    seq_d.cnt   = '0;
                    seq_d.state = RD_STROBE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            RD_STROBE: begin
                if (last_strobe) begin
                    seq_d.cnt   = '0;
                    seq_d.state = RD_RELEASE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            RD_RELEASE: begin
                seq_d.state = RD_IDLE;
            end
            default: seq_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: RD_IDLE, cnt: '0, dev: '0, lo: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready_o  = (seq_q.state == RD_IDLE);
    assign active_o = (seq_q.state != RD_IDLE);
    assign strobe_o = (seq_q.state == RD_STROBE);
    assign take_o   = (seq_q.state == RD_STROBE) && last_strobe;
    assign dev_o    = seq_q.dev;
    assign lo_o     = seq_q.lo;

    // R4
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == RD_STROBE) |-> (int'(seq_q.cnt) < T_OE));

    // R7
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == RD_SETUP && $past(seq_q.state) != RD_SETUP)
            |-> $past(seq_q.state) == RD_IDLE);

endmodule

// File: rtl/eprom_dev_decode.sv
module eprom_dev_decode #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic               en_i,
    input  logic [DEV_W-1:0]   dev_i,
    output logic [NUM_DEV-1:0] ce_n_o
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_ce
        assign ce_n_o[g] = !(en_i && (dev_i == DEV_W'(g)));
    end

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = take_i;
        if (take_i) begin
            cap_d.data = bus_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{data: '0, valid: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign data_o  = cap_q.data;
    assign valid_o = cap_q.valid;

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/eprom_array_reader.sv
module eprom_array_reader #(
    parameter int NUM_DEV    = 4,
    parameter int DEV_ADDR_W = 15,
    parameter int DATA_W     = 8,
    parameter int T_ACC      = 4,
    parameter int T_OE       = 2,
    localparam int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int ADDR_W    = DEV_W + DEV_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic                  ready_o,
    output logic [DATA_W-1:0]     data_o,
    output logic                  valid_o,
    output logic [DEV_ADDR_W-1:0] mem_addr_o,
    output logic [NUM_DEV-1:0]    mem_ce_n_o,
    output logic                  mem_oe_n_o,
    input  logic [DATA_W-1:0]     mem_data_i
);

    logic             active, strobe, take;
    logic [DEV_W-1:0] dev;

    eprom_rd_seq #(
        .DEV_W      (DEV_W),
        .DEV_ADDR_W (DEV_ADDR_W),
        .T_ACC      (T_ACC),
        .T_OE       (T_OE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .addr_i   (addr_i),
        .ready_o  (ready_o),
        .active_o (active),
        .strobe_o (strobe),
        .take_o   (take),
        .dev_o    (dev),
        .lo_o     (mem_addr_o)
    );

    eprom_dev_decode #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_dec (
        .en_i   (active),
        .dev_i  (dev),
        .ce_n_o (mem_ce_n_o)
    );

    eprom_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .bus_i   (mem_data_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    assign mem_oe_n_o = !strobe;

    // R3
    one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n_o));

    // R8
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> ($countones(~mem_ce_n_o) == 1));

    // R8
    sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n_o && !$past(mem_oe_n_o)) |-> ($stable(mem_ce_n_o) && $stable(mem_addr_o)));

    // R6
    oe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n_o) |-> !(&mem_ce_n_o));

    // R6
    no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_ce_n_o) && !(&$past(mem_ce_n_o))) |-> $stable(mem_ce_n_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> ((&mem_ce_n_o) && mem_oe_n_o));

    // R5
    valid_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(!mem_oe_n_o) && mem_oe_n_o));

endmodule

// File: tb/sim_eprom_array_reader.sv
module sim_eprom_array_reader;

    localparam int NUM_DEV    = 4;
    localparam int DEV_ADDR_W = 15;
    localparam int DATA_W     = 8;
    localparam int T_ACC      = 4;
    localparam int T_OE       = 2;
    localparam int DEV_W      = $clog2(NUM_DEV);
    localparam int ADDR_W     = DEV_W + DEV_ADDR_W;
    localparam int N_SETUP    = T_ACC - T_OE;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst_n = 1'b0;
    logic                  req   = 1'b0;
    logic [ADDR_W-1:0]     addr  = '0;
    logic                  ready, valid, oe_n;
    logic [DATA_W-1:0]     data, bus;
    logic [DEV_ADDR_W-1:0] maddr;
    logic [NUM_DEV-1:0]    ce_n;

    int n_chk = 0;
    int n_bad = 0;

    eprom_array_reader #(
        .NUM_DEV (NUM_DEV), .DEV_ADDR_W (DEV_ADDR_W), .DATA_W (DATA_W),
        .T_ACC (T_ACC), .T_OE (T_OE)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .req_i (req), .addr_i (addr),
        .ready_o (ready), .data_o (data), .valid_o (valid),
        .mem_addr_o (maddr), .mem_ce_n_o (ce_n), .mem_oe_n_o (oe_n),
        .mem_data_i (bus)
    );

    function automatic logic [7:0] byte_of(int d, int a);
        return 8'((a * 7) ^ (a >> 5) ^ (d * 61 + 19));
    endfunction

    task automatic chk(bit ok, string req_tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req_tag, what, act, exp, $time);
        end
    endtask

    // Behavioural device bank: unknown data on early access or contention
    int ce_cnt [NUM_DEV];
    int oe_cnt = 0;
    logic [DEV_ADDR_W-1:0] last_ma = '0;

    initial for (int d = 0; d < NUM_DEV; d++) ce_cnt[d] = 0;

    always @(negedge clk) begin
        for (int d = 0; d < NUM_DEV; d++) begin
            if (!ce_n[d]) ce_cnt[d] <= (maddr == last_ma) ? ce_cnt[d] + 1 : 1;
            else          ce_cnt[d] <= 0;
        end
        oe_cnt  <= oe_n ? 0 : oe_cnt + 1;
        last_ma <= maddr;
    end

    always @* begin
        int on;
        on  = 0;
        bus = 'z;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (!ce_n[d] && !oe_n) begin
                on++;
                if (ce_cnt[d] >= T_ACC && oe_cnt >= T_OE && ce_cnt[d] >= oe_cnt + N_SETUP)
                    bus = byte_of(d, int'(maddr));
                else
                    bus = 'x;
            end
        end
        if (on > 1) bus = 'x;
    end

    // Reference model of the host-side read sequence
    logic              r_busy = 1'b0;
    int                r_c    = 0;
    logic [ADDR_W-1:0] r_a    = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            r_busy <= 1'b0;
        end else if (!r_busy) begin
            if (req) begin
                r_busy <= 1'b1;
                r_c    <= 0;
                r_a    <= addr;
            end
        end else if (r_c == T_ACC) begin
            r_busy <= 1'b0;
        end else begin
            r_c <= r_c + 1;
        end
    end

    bit                 cmp_on  = 1'b0;
    logic [NUM_DEV-1:0] prev_ce = '1;
    logic               prev_oe = 1'b1;

    always @(negedge clk) begin
        if (cmp_on) begin
            int dv;
            logic [NUM_DEV-1:0] e_ce;
            logic e_oe, e_val;
            dv    = int'(r_a >> DEV_ADDR_W);
            e_ce  = r_busy ? ~(NUM_DEV'(1) << dv) : '1;
            e_oe  = !(r_busy && r_c >= N_SETUP && r_c < T_ACC);
            e_val = r_busy && r_c == T_ACC;
            chk(ready == !r_busy, "R7", "ready", ready, !r_busy);
            chk(ce_n == e_ce, "R2", "chip enables", ce_n, e_ce);
            chk(oe_n == e_oe, "R4", "output enable", oe_n, e_oe);
            chk(valid == e_val, "R5", "valid", valid, e_val);
            chk($countones(~ce_n) <= 1, "R3", "enabled device count", $countones(~ce_n), 1);
            if (!oe_n) chk($countones(~ce_n) == 1, "R8", "enables under strobe", $countones(~ce_n), 1);
            if (r_busy)
                chk(maddr == r_a[DEV_ADDR_W-1:0], "R2", "device address", maddr, r_a[DEV_ADDR_W-1:0]);
            if (e_val) begin
                chk(!$isunknown(data), "R5", "data known", data, byte_of(dv, int'(r_a[DEV_ADDR_W-1:0])));
                chk(data == byte_of(dv, int'(r_a[DEV_ADDR_W-1:0])), "R5", "data",
                    data, byte_of(dv, int'(r_a[DEV_ADDR_W-1:0])));
            end
            if (oe_n && !prev_oe) chk(ce_n != '1, "R6", "enable held past strobe", ce_n, 0);
            if (ce_n != '1 && prev_ce != '1)
                chk(ce_n == prev_ce, "R6", "device switch without gap", ce_n, prev_ce);
            prev_ce = ce_n;
            prev_oe = oe_n;
        end
    end

    task automatic do_read(logic [ADDR_W-1:0] a);
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        req  = 1'b1;
        addr = a;
        @(negedge clk);
        req  = 1'b0;
        addr = ~a;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ce_n == '1, "R1", "reset chip enables", ce_n, '1);
        chk(oe_n == 1'b1, "R1", "reset output enable", oe_n, 1);
        chk(ready == 1'b1, "R1", "reset ready", ready, 1);
        chk(valid == 1'b0, "R1", "reset valid", valid, 0);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle after reset
        chk(ce_n == '1 && oe_n, "R1", "idle standby", {ce_n, oe_n}, {NUM_DEV'('1), 1'b1});

        // R2: device boundary addresses
        do_read(17'h00000); do_read(17'h07FFF); do_read(17'h08000); do_read(17'h0FFFF);
        do_read(17'h10000); do_read(17'h17FFF); do_read(17'h18000); do_read(17'h1FFFF);

        // R7: request held high with address churning every cycle
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            req  = 1'b1;
            addr = ADDR_W'(i * 40503 + 32'h1234);
        end

        // R7: sparse random requests
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            req  = $urandom_range(0, 2) == 0;
            addr = ADDR_W'($urandom);
        end
        @(negedge clk);
        req = 1'b0;
        repeat (T_ACC + 4) @(negedge clk);
        // R1: back to standby
        chk(ce_n == '1 && oe_n && ready, "R1", "final standby", {ce_n, oe_n}, {NUM_DEV'('1), 1'b1});
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        finish_run();
    end

endmodule